// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block takes bytes from a three-wire, write-only serial link into the system clock domain. The link has an active-low select, a serial clock and a data line. A fourth line marks each byte as either a command or display data. All four inputs pass through two-flop synchronizers. The block detects rising edges of the serial clock in the system clock domain and shifts the data bits in, most significant bit first.

When the eighth bit arrives, the block presents the assembled byte together with a command/data flag and raises a strobe for exactly one system clock cycle. The flag is taken from the mode line as it stands at that eighth bit. While the select stays low, the block receives bytes back to back. Raising the select before a byte is complete discards the partial byte. Asserting the asynchronous reset also discards it, and in neither case is a strobe produced.

Top module: `ser_byte_rx`

## Requirements
- R1: While `rst_ni` is low, `byte_valid_o` is 0, `byte_o` is 8'h00 and `is_data_o` is 0.
- R2: While `sel_ni` is high, rising edges on `sclk_i` are ignored and the bit counter stays at zero, so the first bit after `sel_ni` falls is still bit 7.
- R3: After `sel_ni` falls, `sdat_i` is sampled on each rising edge of `sclk_i`. The first sampled bit lands in `byte_o[7]` and the eighth in `byte_o[0]`.
- R4: `is_data_o` takes the value of `mode_i` sampled with the eighth bit: 0 marks a command byte and 1 marks a display-data byte. Values of `mode_i` at the first seven bits have no effect.
- R5: `byte_valid_o` is high for exactly one system clock cycle per completed byte.
- R6: While `sel_ni` stays low after a byte, the next rising edge of `sclk_i` delivers bit 7 of the following byte, and each byte is emitted in order.
- R7: Asserting `rst_ni` in mid-byte discards the partial byte, and no strobe is produced for it. After release with `sel_ni` low, the next bit received is bit 7 of a new byte.
- R8: If `sel_ni` rises before the eighth bit, the partial byte is discarded without a strobe and the bit counter returns to zero.
- R9: `byte_o` and `is_data_o` change only in a cycle where `byte_valid_o` is high, and they hold the last completed byte otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, aborts any byte in progress |
| sel_ni | input | 1 | Link select, active low; high holds the receiver idle |
| sclk_i | input | 1 | Serial clock, data sampled on its rising edge |
| sdat_i | input | 1 | Serial data, MSB first |
| mode_i | input | 1 | Command (0) or display data (1), read with the eighth bit |
| byte_o | output | 8 | Last completed byte |
| is_data_o | output | 1 | Flag of the last completed byte: 1 = display data |
| byte_valid_o | output | 1 | One-cycle strobe per completed byte |

## Verification
Asymmetric byte values such as A5, 3C, 01 and 80 expose bit-order reversal and one-position shift errors. During each byte the mode line holds the inverse of its final value until the eighth bit, so sampling the flag at any earlier bit gives the wrong flag. Serial clock pulses sent while the link is deselected would shift the following byte if they were counted. Partial bytes cut off by deselect or by reset would show up as extra strobes or as misaligned data in the byte that follows. Back-to-back runs without deselect check that bytes join correctly at their boundaries.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
  typedef struct packed {
    logic sel_n;
    logic sclk;
    logic sdat;
    logic mode;
  } ser_pins_t;

  localparam int unsigned PIN_W = $bits(ser_pins_t);
  // idle pin levels: deselected, clock low
  localparam ser_pins_t PINS_IDLE = '{sel_n: 1'b1, sclk: 1'b0, sdat: 1'b0, mode: 1'b0};
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ser_edge_det.sv
module ser_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_n_i,
  input  logic              rise_i,
  input  logic              sdat_i,
  input  logic              mode_i,
  output logic [DATA_W-1:0] data_o,
  output logic              is_data_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              flag_q, valid_q;
  logic [DATA_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[DATA_W-2:0], sdat_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (sel_n_i) begin
        cnt_q <= '0;  // idle or aborted byte
      end else if (rise_i) begin
        sh_q <= sh_nxt;
        if (cnt_q == LAST) begin
          data_q  <= sh_nxt;
          flag_q  <= mode_i;
          valid_q <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign data_o    = data_q;
  assign is_data_o = flag_q;
  assign valid_o   = valid_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/ser_byte_rx.sv
module ser_byte_rx
  import ser_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              mode_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              is_data_o,
  output logic              byte_valid_o
);
  ser_pins_t        pins_raw, pins_s;
  logic             sclk_rise;
  logic [CNT_W-1:0] bit_cnt;

  assign pins_raw = '{sel_n: sel_ni, sclk: sclk_i, sdat: sdat_i, mode: mode_i};

  ser_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  ser_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pins_s.sclk),
    .rise_o(sclk_rise)
  );

  ser_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_n_i  (pins_s.sel_n),
    .rise_i   (sclk_rise),
    .sdat_i   (pins_s.sdat),
    .mode_i   (pins_s.mode),
    .data_o   (byte_o),
    .is_data_o(is_data_o),
    .valid_o  (byte_valid_o),
    .cnt_o    (bit_cnt)
  );
endmodule

// File: rtl/ser_byte_rx_chk.sv
module ser_byte_rx_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_s_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [DATA_W-1:0] byte_i,
  input logic              is_data_i,
  input logic              valid_i
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i) else $error("valid longer than one cycle"); // R5

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_s_i |=> (cnt_i == '0)) else $error("counter moved while idle"); // R2

  AST_START_AT_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_s_i) |-> (cnt_i == '0)) else $error("transfer began mid-byte"); // R3

  AST_STROBE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($past(cnt_i) == LAST)) else $error("strobe without eighth bit"); // R6

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ($stable(byte_i) && $stable(is_data_i))) else $error("output moved without strobe"); // R9

  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_s_i && cnt_i != '0) |=> (cnt_i == '0 && !valid_i)) else $error("abort left state"); // R8
endmodule

bind ser_byte_rx ser_byte_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_s_i  (pins_s.sel_n),
  .cnt_i    (bit_cnt),
  .byte_i   (byte_o),
  .is_data_i(is_data_o),
  .valid_i  (byte_valid_o)
);

// File: tb/ser_byte_rx_bench.sv
module ser_byte_rx_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF_SCLK  = 4;

  typedef struct {
    logic [7:0] b;
    logic       m;
    string      req;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_ni = 1'b1;
  logic       sclk_i = 1'b0;
  logic       sdat_i = 1'b0;
  logic       mode_i = 1'b0;
  logic [7:0] byte_o;
  logic       is_data_o;
  logic       byte_valid_o;

  int   checks = 0;
  int   errors = 0;
  exp_t exp_q[$];
  logic prev_valid = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ser_byte_rx u_ser_byte_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_ni      (sel_ni),
    .sclk_i      (sclk_i),
    .sdat_i      (sdat_i),
    .mode_i      (mode_i),
    .byte_o      (byte_o),
    .is_data_o   (is_data_o),
    .byte_valid_o(byte_valid_o)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic pulse(input logic d, input logic m);
    sdat_i = d;
    mode_i = m;
    wait_clk(HALF_SCLK);
    sclk_i = 1'b1;
    wait_clk(HALF_SCLK);
    sclk_i = 1'b0;
  endtask

  // mode held inverted until the eighth bit
  task automatic send_byte(input logic [7:0] b, input logic m, input string req);
    exp_t e;
    e.b = b; e.m = m; e.req = req;
    exp_q.push_back(e);
    for (int i = 7; i >= 0; i--) pulse(b[i], (i == 0) ? m : ~m);
  endtask

  task automatic send_partial(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) pulse(b[i], 1'b1);
  endtask

  task automatic set_sel(input logic v);
    sel_ni = v;
    wait_clk(6);
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && byte_valid_o) begin
      checks++;
      if (prev_valid) begin
        errors++;
        $display("FAIL R5: strobe width actual=2+ expected=1");
      end else if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7/R8: unexpected byte actual=%h/%b expected=none", byte_o, is_data_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (byte_o !== e.b || is_data_o !== e.m) begin
          errors++;
          $display("FAIL %s: byte actual=%h/%b expected=%h/%b", e.req, byte_o, is_data_o, e.b, e.m);
        end
      end
    end
    prev_valid = byte_valid_o;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    wait_clk(3);
    checks++; // R1
    if (byte_o !== 8'h00 || is_data_o !== 1'b0 || byte_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs actual=%h/%b/%b expected=00/0/0", byte_o, is_data_o, byte_valid_o);
    end
    rst_ni = 1'b1;
    wait_clk(4);

    // R3, R4: single data byte, MSB first
    set_sel(1'b0);
    send_byte(8'hA5, 1'b1, "R3");
    set_sel(1'b1);

    // R2: clock pulses while deselected must not shift
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b1);
    checks++;
    if (byte_valid_o !== 1'b0 || byte_o !== 8'hA5) begin
      errors++;
      $display("FAIL R2: idle outputs actual=%h expected=a5", byte_o);
    end
    set_sel(1'b0);
    send_byte(8'h3C, 1'b0, "R2");
    set_sel(1'b1);

    // R6: back-to-back bytes, flag follows eighth bit (R4)
    set_sel(1'b0);
    send_byte(8'h01, 1'b1, "R6");
    send_byte(8'h80, 1'b0, "R6");
    send_byte(8'hFF, 1'b1, "R4");
    send_byte(8'h00, 1'b0, "R4");
    set_sel(1'b1);

    // R8: deselect mid-byte
    set_sel(1'b0);
    send_partial(8'hFF, 5);
    set_sel(1'b1);
    checks++;
    if (byte_o !== 8'h00 || is_data_o !== 1'b0) begin
      errors++;
      $display("FAIL R8: held output actual=%h/%b expected=00/0", byte_o, is_data_o);
    end
    set_sel(1'b0);
    send_byte(8'h5A, 1'b1, "R8");
    set_sel(1'b1);

    // R7: reset mid-byte, select stays low
    set_sel(1'b0);
    send_partial(8'hFF, 3);
    rst_ni = 1'b0;
    wait_clk(3);
    checks++;
    if (byte_o !== 8'h00 || byte_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R7: outputs in reset actual=%h/%b expected=00/0", byte_o, byte_valid_o);
    end
    rst_ni = 1'b1;
    wait_clk(8);
    send_byte(8'hC3, 1'b0, "R7");
    send_byte(8'h96, 1'b1, "R7");
    set_sel(1'b1);

    wait_clk(20);
    checks++; // R6: every byte delivered
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6: missing bytes actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule